// File: doc/BRIEF.md
# Section-Based Harvard Address Router

This block sits between one requesting master and two downstream targets, a data memory port and an instruction memory port, that together share one flat address space. The top byte of each request address is treated as a section number. Two inclusive section windows, each given by a lower and an upper bound on configuration inputs, decide where a request goes. The data window is tested first, and the instruction window only when the data window misses.

Before the request leaves, the address is rebased so that the selected target sees an offset from the start of its own window. A request that hits neither window never reaches a target. It is answered locally with an "unmapped" status. Downstream responses are returned to the master with their read data and a translated status.

The router holds at most one request at a time. It stays busy from acceptance until its response pulse has been given.

Top module: `sec_router`

## Requirements
- R1: The section number is address bits [31:24]. A request whose section s satisfies d_lo <= s <= d_hi (inclusive at both ends) is forwarded on the data port only.
- R2: When the data window misses and i_lo <= s <= i_hi, the request is forwarded on the instruction port only.
- R3: When both windows contain the section, the data port is chosen.
- R4: An address forwarded on the data port equals the incoming address minus (d_lo << 24), modulo 2^32.
- R5: An address forwarded on the instruction port equals the incoming address minus (i_lo << 24), modulo 2^32.
- R6: A request that hits neither window raises no downstream valid. In the cycle after acceptance it gives a one-cycle response with status 2'b01 (unmapped) and read data zero.
- R7: A downstream response is returned in the cycle after it arrives. It carries the downstream read data and has status 2'b10 when the downstream error bit is set, otherwise 2'b00.
- R8: up_req_ready is high when idle. It is low from the cycle after acceptance through the response cycle, so only one request is outstanding.
- R9: A forwarded request keeps its valid, address, write flag, size and write data (the last three copied from the master) unchanged until the target asserts ready, and drops valid in the cycle after.
- R10: Window bounds are sampled only at acceptance. Changing them afterwards alters neither the chosen port nor the forwarded address of that request.
- R11: After reset, up_req_ready is high and up_rsp_valid, d_req_valid and i_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_d_lo | input | 8 | First section of the data window |
| cfg_d_hi | input | 8 | Last section of the data window |
| cfg_i_lo | input | 8 | First section of the instruction window |
| cfg_i_hi | input | 8 | Last section of the instruction window |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Router can accept a request |
| up_req_addr | input | 32 | Master request address |
| up_req_we | input | 1 | Write when high |
| up_req_size | input | 2 | Access size code, passed through |
| up_req_wdata | input | 32 | Write data |
| up_rsp_valid | output | 1 | Response pulse to the master |
| up_rsp_status | output | 2 | 00 ok, 01 unmapped, 10 downstream error |
| up_rsp_rdata | output | 32 | Response read data |
| d_req_valid | output | 1 | Data port request valid |
| d_req_ready | input | 1 | Data port accepts request |
| d_req_addr | output | 32 | Rebased address to data port |
| d_req_we | output | 1 | Write flag to data port |
| d_req_size | output | 2 | Size code to data port |
| d_req_wdata | output | 32 | Write data to data port |
| d_rsp_valid | input | 1 | Data port response valid |
| d_rsp_err | input | 1 | Data port response error |
| d_rsp_rdata | input | 32 | Data port read data |
| i_req_valid | output | 1 | Instruction port request valid |
| i_req_ready | input | 1 | Instruction port accepts request |
| i_req_addr | output | 32 | Rebased address to instruction port |
| i_req_we | output | 1 | Write flag to instruction port |
| i_req_size | output | 2 | Size code to instruction port |
| i_req_wdata | output | 32 | Write data to instruction port |
| i_rsp_valid | input | 1 | Instruction port response valid |
| i_rsp_err | input | 1 | Instruction port response error |
| i_rsp_rdata | input | 32 | Instruction port read data |

## Verification
A request accepted at a clock edge shows up on its target port in the next cycle. For a miss, the unmapped response pulse appears in that same next cycle instead. The downstream request drops one cycle after the edge where ready is seen. The master response is due one cycle after the edge where the downstream response is sampled, and up_req_ready returns one cycle after that. The bench steps through each transaction on falling edges. After every rising edge it predicts the state of every output and compares it, so each result is checked in the cycle it is due and also found absent in the cycles around it. Window edges (first, last, one below, one above) are tried for both windows, together with overlapping windows, single-section windows, target stalls, response delays and error responses.

// File: rtl/sec_router_pkg.sv
package sec_router_pkg;

   typedef enum logic [1:0] {
      RSP_OK       = 2'b00,
      RSP_UNMAPPED = 2'b01,
      RSP_DNERR    = 2'b10
   } rsp_stat_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'b00,
      TGT_DATA = 2'b01,
      TGT_INSN = 2'b10
   } tgt_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ISSUE,
      S_WAIT,
      S_RESP
   } rtr_state_e;

   localparam int unsigned PORT_DATA = 0;
   localparam int unsigned PORT_INSN = 1;
   localparam int unsigned N_PORTS   = 2;

endpackage

// File: rtl/sec_range_cmp.sv
module sec_range_cmp #(
   parameter int unsigned SEC_W = 8
) (
   input  logic [SEC_W-1:0] sec,
   input  logic [SEC_W-1:0] lo,
   input  logic [SEC_W-1:0] hi,
   output logic             hit
);
   assign hit = (sec >= lo) && (sec <= hi);
endmodule

// File: rtl/sec_decode.sv
module sec_decode
   import sec_router_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SEC_W  = 8,
   parameter bit          REBASE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEC_W-1:0]  d_lo,
   input  logic [SEC_W-1:0]  d_hi,
   input  logic [SEC_W-1:0]  i_lo,
   input  logic [SEC_W-1:0]  i_hi,
   output tgt_e              tgt,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int unsigned OFS_W = ADDR_W - SEC_W;

   logic [SEC_W-1:0]        sec;
   logic [N_PORTS-1:0]      hit;
   logic [N_PORTS-1:0][SEC_W-1:0] lo_v;
   logic [N_PORTS-1:0][SEC_W-1:0] hi_v;
   logic [SEC_W-1:0]        base_sec;
   logic [ADDR_W-1:0]       base;

   assign sec             = addr[ADDR_W-1 -: SEC_W];
   assign lo_v[PORT_DATA] = d_lo;
   assign hi_v[PORT_DATA] = d_hi;
   assign lo_v[PORT_INSN] = i_lo;
   assign hi_v[PORT_INSN] = i_hi;

   for (genvar g = 0; g < N_PORTS; g++) begin : g_win
      sec_range_cmp #(.SEC_W(SEC_W)) u_cmp (
         .sec (sec),
         .lo  (lo_v[g]),
         .hi  (hi_v[g]),
         .hit (hit[g])
      );
   end

   // data window has priority over the instruction window
   always_comb begin
      if (hit[PORT_DATA]) begin
         tgt      = TGT_DATA;
         base_sec = d_lo;
      end else if (hit[PORT_INSN]) begin
         tgt      = TGT_INSN;
         base_sec = i_lo;
      end else begin
         tgt      = TGT_NONE;
         base_sec = '0;
      end
   end

   assign base = {base_sec, {OFS_W{1'b0}}};

   if (REBASE) begin : g_rebase
      assign addr_out = addr - base;
   end else begin : g_flat
      assign addr_out = addr;
   end

   // R3: an overlap never hands the request to the instruction side
   always_comb begin
      a_r3_data_first : assert (!(hit[PORT_DATA] && (tgt != TGT_DATA)));
   end

endmodule

// File: rtl/sec_router_ctrl.sv
module sec_router_ctrl
   import sec_router_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SIZE_W = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            up_req_valid,
   output logic                            up_req_ready,
   input  tgt_e                            dec_tgt,
   input  logic [ADDR_W-1:0]               dec_addr,
   input  logic                            up_req_we,
   input  logic [SIZE_W-1:0]               up_req_size,
   input  logic [DATA_W-1:0]               up_req_wdata,
   output logic                            up_rsp_valid,
   output logic [1:0]                      up_rsp_status,
   output logic [DATA_W-1:0]               up_rsp_rdata,
   output logic [N_PORTS-1:0]              dn_valid,
   input  logic [N_PORTS-1:0]              dn_ready,
   output logic [ADDR_W-1:0]               dn_addr,
   output logic                            dn_we,
   output logic [SIZE_W-1:0]               dn_size,
   output logic [DATA_W-1:0]               dn_wdata,
   input  logic [N_PORTS-1:0]              dn_rsp_valid,
   input  logic [N_PORTS-1:0]              dn_rsp_err,
   input  logic [N_PORTS-1:0][DATA_W-1:0]  dn_rsp_rdata
);
   localparam int unsigned SEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

   rtr_state_e         st;
   logic [SEL_W-1:0]   sel_q;
   logic [ADDR_W-1:0]  addr_q;
   logic               we_q;
   logic [SIZE_W-1:0]  size_q;
   logic [DATA_W-1:0]  wdata_q;
   rsp_stat_e          stat_q;
   logic [DATA_W-1:0]  rdata_q;
   logic               accept;

   assign up_req_ready = (st == S_IDLE);
   assign accept       = up_req_valid && up_req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         sel_q   <= '0;
         addr_q  <= '0;
         we_q    <= 1'b0;
         size_q  <= '0;
         wdata_q <= '0;
         stat_q  <= RSP_OK;
         rdata_q <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (accept) begin
                  addr_q  <= dec_addr;
                  we_q    <= up_req_we;
                  size_q  <= up_req_size;
                  wdata_q <= up_req_wdata;
                  if (dec_tgt == TGT_NONE) begin
                     stat_q  <= RSP_UNMAPPED;
                     rdata_q <= '0;
                     st      <= S_RESP;
                  end else begin
                     sel_q <= (dec_tgt == TGT_INSN) ? SEL_W'(PORT_INSN) : SEL_W'(PORT_DATA);
                     st    <= S_ISSUE;
                  end
               end
            end
            S_ISSUE: begin
               if (dn_ready[sel_q]) st <= S_WAIT;
            end
            S_WAIT: begin
               if (dn_rsp_valid[sel_q]) begin
                  stat_q  <= dn_rsp_err[sel_q] ? RSP_DNERR : RSP_OK;
                  rdata_q <= dn_rsp_rdata[sel_q];
                  st      <= S_RESP;
               end
            end
            S_RESP: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      assign dn_valid[p] = (st == S_ISSUE) && (sel_q == SEL_W'(p));
   end

   assign dn_addr       = addr_q;
   assign dn_we         = we_q;
   assign dn_size       = size_q;
   assign dn_wdata      = wdata_q;
   assign up_rsp_valid  = (st == S_RESP);
   assign up_rsp_status = stat_q;
   assign up_rsp_rdata  = rdata_q;

   a_r8_busy_no_accept : assert property (@(posedge clk) disable iff (!rst_n)
      up_rsp_valid |-> !up_req_ready);

   a_r6_rsp_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      up_rsp_valid |=> !up_rsp_valid);

   a_r6_miss_local : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_tgt == TGT_NONE) |=>
         (up_rsp_valid && up_rsp_status == RSP_UNMAPPED && dn_valid == '0));

   a_r2_one_target : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_valid));

   a_r9_hold_request : assert property (@(posedge clk) disable iff (!rst_n)
      (|(dn_valid & ~dn_ready)) |=>
         ((dn_valid == $past(dn_valid)) && $stable(dn_addr) && $stable(dn_wdata)));

   a_r7_error_status : assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT && dn_rsp_valid[sel_q] && dn_rsp_err[sel_q]) |=>
         (up_rsp_valid && up_rsp_status == RSP_DNERR));

endmodule

// File: rtl/sec_router.sv
module sec_router
   import sec_router_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SEC_W  = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SIZE_W = 2,
   parameter bit          REBASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEC_W-1:0]  cfg_d_lo,
   input  logic [SEC_W-1:0]  cfg_d_hi,
   input  logic [SEC_W-1:0]  cfg_i_lo,
   input  logic [SEC_W-1:0]  cfg_i_hi,
   input  logic              up_req_valid,
   output logic              up_req_ready,
   input  logic [ADDR_W-1:0] up_req_addr,
   input  logic              up_req_we,
   input  logic [SIZE_W-1:0] up_req_size,
   input  logic [DATA_W-1:0] up_req_wdata,
   output logic              up_rsp_valid,
   output logic [1:0]        up_rsp_status,
   output logic [DATA_W-1:0] up_rsp_rdata,
   output logic              d_req_valid,
   input  logic              d_req_ready,
   output logic [ADDR_W-1:0] d_req_addr,
   output logic              d_req_we,
   output logic [SIZE_W-1:0] d_req_size,
   output logic [DATA_W-1:0] d_req_wdata,
   input  logic              d_rsp_valid,
   input  logic              d_rsp_err,
   input  logic [DATA_W-1:0] d_rsp_rdata,
   output logic              i_req_valid,
   input  logic              i_req_ready,
   output logic [ADDR_W-1:0] i_req_addr,
   output logic              i_req_we,
   output logic [SIZE_W-1:0] i_req_size,
   output logic [DATA_W-1:0] i_req_wdata,
   input  logic              i_rsp_valid,
   input  logic              i_rsp_err,
   input  logic [DATA_W-1:0] i_rsp_rdata
);
   if (SEC_W < 1 || SEC_W >= ADDR_W) begin : g_bad_sec
      $error("sec_router: SEC_W must be between 1 and ADDR_W-1");
   end
   if (DATA_W < 8 || SIZE_W < 1) begin : g_bad_data
      $error("sec_router: DATA_W must be at least 8 and SIZE_W at least 1");
   end

   tgt_e                           dec_tgt;
   logic [ADDR_W-1:0]              dec_addr;
   logic [N_PORTS-1:0]             dn_valid;
   logic [N_PORTS-1:0]             dn_ready;
   logic [ADDR_W-1:0]              dn_addr;
   logic                           dn_we;
   logic [SIZE_W-1:0]              dn_size;
   logic [DATA_W-1:0]              dn_wdata;
   logic [N_PORTS-1:0]             dn_rsp_valid;
   logic [N_PORTS-1:0]             dn_rsp_err;
   logic [N_PORTS-1:0][DATA_W-1:0] dn_rsp_rdata;

   sec_decode #(
      .ADDR_W (ADDR_W),
      .SEC_W  (SEC_W),
      .REBASE (REBASE)
   ) u_dec (
      .addr     (up_req_addr),
      .d_lo     (cfg_d_lo),
      .d_hi     (cfg_d_hi),
      .i_lo     (cfg_i_lo),
      .i_hi     (cfg_i_hi),
      .tgt      (dec_tgt),
      .addr_out (dec_addr)
   );

   sec_router_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SIZE_W (SIZE_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .up_req_valid  (up_req_valid),
      .up_req_ready  (up_req_ready),
      .dec_tgt       (dec_tgt),
      .dec_addr      (dec_addr),
      .up_req_we     (up_req_we),
      .up_req_size   (up_req_size),
      .up_req_wdata  (up_req_wdata),
      .up_rsp_valid  (up_rsp_valid),
      .up_rsp_status (up_rsp_status),
      .up_rsp_rdata  (up_rsp_rdata),
      .dn_valid      (dn_valid),
      .dn_ready      (dn_ready),
      .dn_addr       (dn_addr),
      .dn_we         (dn_we),
      .dn_size       (dn_size),
      .dn_wdata      (dn_wdata),
      .dn_rsp_valid  (dn_rsp_valid),
      .dn_rsp_err    (dn_rsp_err),
      .dn_rsp_rdata  (dn_rsp_rdata)
   );

   assign d_req_valid             = dn_valid[PORT_DATA];
   assign i_req_valid             = dn_valid[PORT_INSN];
   assign dn_ready[PORT_DATA]     = d_req_ready;
   assign dn_ready[PORT_INSN]     = i_req_ready;
   assign dn_rsp_valid[PORT_DATA] = d_rsp_valid;
   assign dn_rsp_valid[PORT_INSN] = i_rsp_valid;
   assign dn_rsp_err[PORT_DATA]   = d_rsp_err;
   assign dn_rsp_err[PORT_INSN]   = i_rsp_err;
   assign dn_rsp_rdata[PORT_DATA] = d_rsp_rdata;
   assign dn_rsp_rdata[PORT_INSN] = i_rsp_rdata;

   assign d_req_addr  = dn_addr;
   assign d_req_we    = dn_we;
   assign d_req_size  = dn_size;
   assign d_req_wdata = dn_wdata;
   assign i_req_addr  = dn_addr;
   assign i_req_we    = dn_we;
   assign i_req_size  = dn_size;
   assign i_req_wdata = dn_wdata;

endmodule

// File: tb/tb_sec_router.sv
`timescale 1ns/1ps
module tb_sec_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_d_lo = 8'h10, cfg_d_hi = 8'h1F, cfg_i_lo = 8'h20, cfg_i_hi = 8'h2F;
   logic        up_req_valid = 1'b0;
   logic        up_req_ready;
   logic [31:0] up_req_addr = '0;
   logic        up_req_we = 1'b0;
   logic [1:0]  up_req_size = '0;
   logic [31:0] up_req_wdata = '0;
   logic        up_rsp_valid;
   logic [1:0]  up_rsp_status;
   logic [31:0] up_rsp_rdata;
   logic        d_req_valid, i_req_valid;
   logic        d_req_ready = 1'b0, i_req_ready = 1'b0;
   logic [31:0] d_req_addr, i_req_addr, d_req_wdata, i_req_wdata;
   logic        d_req_we, i_req_we;
   logic [1:0]  d_req_size, i_req_size;
   logic        d_rsp_valid = 1'b0, i_rsp_valid = 1'b0;
   logic        d_rsp_err = 1'b0, i_rsp_err = 1'b0;
   logic [31:0] d_rsp_rdata = '0, i_rsp_rdata = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sec_router dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_d_lo(cfg_d_lo), .cfg_d_hi(cfg_d_hi), .cfg_i_lo(cfg_i_lo), .cfg_i_hi(cfg_i_hi),
      .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_addr(up_req_addr),
      .up_req_we(up_req_we), .up_req_size(up_req_size), .up_req_wdata(up_req_wdata),
      .up_rsp_valid(up_rsp_valid), .up_rsp_status(up_rsp_status), .up_rsp_rdata(up_rsp_rdata),
      .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_addr(d_req_addr),
      .d_req_we(d_req_we), .d_req_size(d_req_size), .d_req_wdata(d_req_wdata),
      .d_rsp_valid(d_rsp_valid), .d_rsp_err(d_rsp_err), .d_rsp_rdata(d_rsp_rdata),
      .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_addr(i_req_addr),
      .i_req_we(i_req_we), .i_req_size(i_req_size), .i_req_wdata(i_req_wdata),
      .i_rsp_valid(i_rsp_valid), .i_rsp_err(i_rsp_err), .i_rsp_rdata(i_rsp_rdata)
   );

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Idle-state outputs: R8 ready high, R11/R6 nothing pending
   task automatic chk_idle(input string req);
      cmp({req, " ready"}, 32'(up_req_ready), 32'd1);
      cmp({req, " rsp_valid"}, 32'(up_rsp_valid), 32'd0);
      cmp({req, " dn_valid"}, {30'd0, i_req_valid, d_req_valid}, 32'd0);
   endtask

   // Behavioural reference: 0 none, 1 data, 2 instruction
   function automatic int route(input logic [31:0] a, output logic [31:0] ra);
      logic [7:0] s = a[31:24];
      ra = a;
      if (s >= cfg_d_lo && s <= cfg_d_hi) begin
         ra = a - {cfg_d_lo, 24'd0};
         return 1;
      end
      if (s >= cfg_i_lo && s <= cfg_i_hi) begin
         ra = a - {cfg_i_lo, 24'd0};
         return 2;
      end
      return 0;
   endfunction

   task automatic xact(input logic [31:0] a, input logic we, input logic [1:0] sz,
                       input logic [31:0] wd, input int stall, input int lat,
                       input logic err, input logic [31:0] rd, input bit poke);
      logic [31:0] ea;
      int          t;
      logic [7:0]  sv_dl, sv_dh, sv_il, sv_ih;
      t = route(a, ea);
      @(negedge clk);
      chk_idle("R8 idle before request");
      up_req_valid = 1'b1; up_req_addr = a; up_req_we = we;
      up_req_size = sz; up_req_wdata = wd;
      @(negedge clk);
      up_req_valid = 1'b0;
      sv_dl = cfg_d_lo; sv_dh = cfg_d_hi; sv_il = cfg_i_lo; sv_ih = cfg_i_hi;
      if (poke) begin
         // R10: disturb the windows after acceptance
         cfg_d_lo = ~cfg_d_lo; cfg_d_hi = 8'h00; cfg_i_lo = 8'hFF; cfg_i_hi = 8'h00;
      end
      if (t == 0) begin
         cmp("R6 unmapped rsp_valid", 32'(up_rsp_valid), 32'd1);
         cmp("R6 unmapped status", 32'(up_rsp_status), 32'd1);
         cmp("R6 unmapped rdata", up_rsp_rdata, 32'd0);
         cmp("R6 no downstream valid", {30'd0, i_req_valid, d_req_valid}, 32'd0);
         cmp("R8 busy during response", 32'(up_req_ready), 32'd0);
      end else begin
         for (int s = 0; s <= stall; s++) begin
            cmp("R1 data port valid", 32'(d_req_valid), 32'(t == 1));
            cmp("R2 insn port valid", 32'(i_req_valid), 32'(t == 2));
            cmp("R8 busy while issued", 32'(up_req_ready), 32'd0);
            cmp("R8 no early response", 32'(up_rsp_valid), 32'd0);
            if (t == 1) begin
               cmp("R4 data rebased addr", d_req_addr, ea);
               cmp("R9 data we/size", {29'd0, d_req_we, d_req_size}, {29'd0, we, sz});
               cmp("R9 data wdata", d_req_wdata, wd);
            end else begin
               cmp("R5 insn rebased addr", i_req_addr, ea);
               cmp("R9 insn we/size", {29'd0, i_req_we, i_req_size}, {29'd0, we, sz});
               cmp("R9 insn wdata", i_req_wdata, wd);
            end
            if (s == stall) begin
               if (t == 1) d_req_ready = 1'b1; else i_req_ready = 1'b1;
            end
            @(negedge clk);
         end
         d_req_ready = 1'b0; i_req_ready = 1'b0;
         cmp("R9 valid drops after ready", {30'd0, i_req_valid, d_req_valid}, 32'd0);
         for (int l = 0; l < lat; l++) begin
            cmp("R7 no response before downstream", 32'(up_rsp_valid), 32'd0);
            cmp("R8 busy while waiting", 32'(up_req_ready), 32'd0);
            @(negedge clk);
         end
         if (t == 1) begin
            d_rsp_valid = 1'b1; d_rsp_err = err; d_rsp_rdata = rd;
         end else begin
            i_rsp_valid = 1'b1; i_rsp_err = err; i_rsp_rdata = rd;
         end
         @(negedge clk);
         d_rsp_valid = 1'b0; i_rsp_valid = 1'b0; d_rsp_err = 1'b0; i_rsp_err = 1'b0;
         cmp("R7 response valid", 32'(up_rsp_valid), 32'd1);
         cmp("R7 response status", 32'(up_rsp_status), err ? 32'd2 : 32'd0);
         cmp("R7 response rdata", up_rsp_rdata, rd);
         cmp("R8 busy during response", 32'(up_req_ready), 32'd0);
      end
      cfg_d_lo = sv_dl; cfg_d_hi = sv_dh; cfg_i_lo = sv_il; cfg_i_hi = sv_ih;
      @(negedge clk);
      chk_idle("R8 idle after response");
   endtask

   task automatic set_cfg(input logic [7:0] dl, input logic [7:0] dh,
                          input logic [7:0] il, input logic [7:0] ih);
      cfg_d_lo = dl; cfg_d_hi = dh; cfg_i_lo = il; cfg_i_hi = ih;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state, sampled while still in reset and after release
      chk_idle("R11 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R11 after reset");

      // Disjoint windows 0x10..0x1F data, 0x20..0x2F instruction
      set_cfg(8'h10, 8'h1F, 8'h20, 8'h2F);
      xact(32'h1000_0004, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'hCAFE_0001, 1'b0); // R1 first
      xact(32'h1FFF_FFFC, 1'b1, 2'd1, 32'hA5A5_1234, 2, 1, 1'b0, 32'h0, 1'b0); // R1 last, R4
      xact(32'h0FFF_FFFF, 1'b0, 2'd0, 32'h0, 0, 0, 1'b0, 32'h0, 1'b0);        // R6 first-1
      xact(32'h2000_0000, 1'b0, 2'd3, 32'h0, 1, 3, 1'b0, 32'h1111_2222, 1'b0); // R2 first, R5
      xact(32'h2F12_3456, 1'b1, 2'd2, 32'hDEAD_BEEF, 0, 2, 1'b1, 32'h0BAD_0BAD, 1'b0); // R2 last, R7 error
      xact(32'h3000_0000, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h0, 1'b0);        // R6 last+1

      // Overlapping windows: data 0x40..0x60, instruction 0x50..0x70
      set_cfg(8'h40, 8'h60, 8'h50, 8'h70);
      xact(32'h5500_0010, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h7777_8888, 1'b0); // R3 overlap
      xact(32'h5000_0000, 1'b0, 2'd2, 32'h0, 0, 1, 1'b1, 32'h1, 1'b0);         // R3 insn first in data
      xact(32'h6100_0020, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h2468_ACE0, 1'b0); // R2 data last+1
      xact(32'h70FF_FFFF, 1'b1, 2'd0, 32'h0000_00FF, 3, 0, 1'b0, 32'h0, 1'b0); // R2 insn last
      xact(32'h7100_0000, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h0, 1'b0);        // R6 insn last+1
      xact(32'h3FFF_FFFF, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h0, 1'b0);        // R6 data first-1

      // Single-section windows at both ends of the section range
      set_cfg(8'h00, 8'h00, 8'hFF, 8'hFF);
      xact(32'h0012_3456, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h0000_0042, 1'b0); // R4 base zero
      xact(32'hFF00_0008, 1'b0, 2'd2, 32'h0, 1, 1, 1'b0, 32'h9999_0000, 1'b0); // R5 top section
      xact(32'hFEFF_FFFF, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h0, 1'b0);        // R6 insn first-1
      xact(32'h0100_0000, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h0, 1'b0);        // R6 data last+1

      // Empty data window (lo > hi) leaves only the instruction window
      set_cfg(8'h80, 8'h7F, 8'h80, 8'h8F);
      xact(32'h8000_1000, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h5555_AAAA, 1'b0); // R2

      // R10: bounds changed after acceptance do not disturb the request
      set_cfg(8'h10, 8'h1F, 8'h20, 8'h2F);
      xact(32'h1800_0040, 1'b1, 2'd2, 32'h0F0F_0F0F, 2, 2, 1'b0, 32'h0, 1'b1);
      xact(32'h2400_0040, 1'b0, 2'd1, 32'h0, 1, 0, 1'b1, 32'h3C3C_3C3C, 1'b1);
      xact(32'hC000_0000, 1'b0, 2'd2, 32'h0, 0, 0, 1'b0, 32'h0, 1'b1);

      repeat (2) @(negedge clk);
      summary();
   end

endmodule